// File: doc/BRIEF.md
# Tuning Command Sequencer

This block runs tune and station-search commands against an abstracted local oscillator, represented only by a 10-bit tune position held inside the block. A host first loads the low byte of a 16-bit target and then the high byte. Loading the high byte while the radio is powered and no command is running launches a command. The grid select input, sampled at launch, picks the kind of command. A zero grid gives a direct tune: the position jumps to the target in one cycle. A nonzero grid gives a search. The search walks the position one grid step per cycle in the direction given by the top target bit and stops on the first position where the external station-found input is high.

The search fails if the next step would run past the limit held in the target's low ten bits, or past either band edge. Results appear as a 3-bit error code, a tuned flag and a one-cycle completion pulse. A command can be forcibly ended by an abort strobe, which the surrounding register file raises on any write to its identity register. Dropping radio power also ends a command forcibly.

Top module: `tune_cmd_seq`

## Requirements
- R1: After reset the error code is 1, the position is 0, and busy, tuned and the completion pulse are all 0.
- R2: A high-byte write taken while power is on and the block is idle starts a command. From the next cycle on, busy is 1, the error code reads 7 and tuned is 0. A high-byte write with power off changes nothing.
- R3: With grid 0 and target bits [15:10] all zero, the command occupies exactly one busy cycle. It ends with the position equal to target[9:0], error code 0 and tuned set to 1.
- R4: With grid 0 and any of target bits [15:10] set, the command ends with error code 3. The position is unchanged and tuned stays 0.
- R5: A search moves the position by 1, 2 or 4 per cycle for grid 1, 2 or 3. It counts up when target bit 15 is 0 and down when it is 1; target bit 14 is reserved. Station-found is tested at the launch position and at every position reached. When it is high, the search ends with error code 0, tuned set to 1 and the position left at the station.
- R6: A search that finds no station ends with error code 2 and tuned at 0. It ends when the next step would go above the limit target[9:0] or 1023 (upward search), or below the limit or 0 (downward search). The position stays at the last reachable grid point, and the busy time is one cycle per visited position.
- R7: An abort strobe during a command ends it in the next cycle with error code 6, busy at 0 and tuned at 0. An abort strobe while idle has no effect.
- R8: While power is off, tuned is cleared. Power going off during a command ends the command with error code 6.
- R9: Low-byte and high-byte writes taken while busy are ignored. They neither restart the command nor alter the stored limit or the low byte used by the next command.
- R10: Every command end (success, error, abort or power loss) raises the completion pulse for exactly one cycle, in the same cycle that busy falls.
- R11: A command's target is the high byte written at launch joined to the most recent low byte accepted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_lo_wr | input | 1 | Strobe: load tgt_byte as the target low byte |
| tgt_hi_wr | input | 1 | Strobe: tgt_byte is the target high byte; launches a command |
| tgt_byte | input | 8 | Target byte being written |
| grid_sel | input | 2 | 0 direct tune, 1/2/3 search step of 1/2/4 positions |
| pwr_en | input | 1 | Radio power enable |
| abort_req | input | 1 | Forced-end strobe |
| stn_found | input | 1 | Station present at the current position |
| tune_pos | output | 10 | Current tune position |
| err_code | output | 3 | Result code: 0 ok, 1 reset, 2 band/limit, 3 range, 6 forced, 7 busy |
| busy | output | 1 | Command running |
| tuned | output | 1 | Last command tuned or found a station |
| cmd_done | output | 1 | One-cycle command-end event |

## Verification
Searches are swept over all three grids in both directions. For each, the station is placed on the grid, placed off the grid, or left absent. The aligned case shows the step size is correct. The misaligned case shows the block cannot stop between grid points. The absent case shows the limit and band-edge stopping rules, along with busy-cycle counts that expose an off-by-one step. Band-edge runs near 0 and 1023 separate the limit test from the edge test. Further runs launch a search already past its limit, write target bytes mid-search, abort, and drop power; these show that each guard acts on its own.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   typedef enum logic [2:0] {
      ERR_OK    = 3'd0,
      ERR_RST   = 3'd1,
      ERR_BAND  = 3'd2,
      ERR_DAC   = 3'd3,
      ERR_FORCE = 3'd6,
      ERR_BUSY  = 3'd7
   } tcs_err_e;

endpackage

// File: rtl/tcs_target_reg.sv
module tcs_target_reg #(
   parameter int BYTE_W = 8,
   parameter int TGT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_wr,
   input  logic              hi_wr,
   input  logic              hold,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [TGT_W-1:0]  tgt_full,
   output logic              start_req
);

   generate
      if (TGT_W != 2 * BYTE_W) begin : g_bad_width
         $error("tcs_target_reg: TGT_W must be twice BYTE_W");
      end
   endgenerate

   logic [BYTE_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
      end else if (lo_wr && !hold) begin
         lo_q <= byte_in;
      end
   end

   assign tgt_full  = {byte_in, lo_q};
   assign start_req = hi_wr && !hold;

endmodule

// File: rtl/tcs_stepper.sv
module tcs_stepper #(
   parameter int POS_W    = 10,
   parameter int GRID_W   = 2,
   parameter int BAND_MAX = (1 << POS_W) - 1
) (
   input  logic [POS_W-1:0]  pos,
   input  logic [GRID_W-1:0] grid,
   input  logic              dir_dn,
   input  logic [POS_W-1:0]  limit,
   output logic [POS_W-1:0]  nxt_pos,
   output logic              over
);

   localparam int EXT_W    = POS_W + 1;
   localparam int MAX_STEP = 1 << ((1 << GRID_W) - 2);

   generate
      if (BAND_MAX > (1 << POS_W) - 1 || BAND_MAX < 1) begin : g_bad_band
         $error("tcs_stepper: BAND_MAX outside the position range");
      end
      if (MAX_STEP >= (1 << POS_W)) begin : g_bad_step
         $error("tcs_stepper: largest grid step does not fit the position");
      end
   endgenerate

   logic [EXT_W-1:0] step;
   logic [EXT_W-1:0] sum;
   logic [EXT_W-1:0] diff;
   logic             up_edge;
   logic             up_out;
   logic             dn_out;

   always_comb begin
      step = '0;
      if (grid != '0) begin
         step = EXT_W'(1) << (grid - GRID_W'(1));
      end
   end

   assign sum  = {1'b0, pos} + step;
   assign diff = {1'b0, pos} - step;

   generate
      if (BAND_MAX == (1 << POS_W) - 1) begin : g_full_band
         assign up_edge = sum[POS_W];
      end else begin : g_part_band
         assign up_edge = sum > EXT_W'(BAND_MAX);
      end
   endgenerate

   assign up_out  = up_edge || (sum > {1'b0, limit});
   assign dn_out  = ({1'b0, pos} < step) || (diff < {1'b0, limit});
   assign over    = dir_dn ? dn_out : up_out;
   assign nxt_pos = dir_dn ? diff[POS_W-1:0] : sum[POS_W-1:0];

endmodule

// File: rtl/tcs_ctrl.sv
module tcs_ctrl
   import tcs_pkg::*;
#(
   parameter int POS_W  = 10,
   parameter int TGT_W  = 16,
   parameter int GRID_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic [TGT_W-1:0]  tgt_full,
   input  logic [GRID_W-1:0] grid_sel,
   input  logic              pwr_en,
   input  logic              abort_req,
   input  logic              stn_found,
   input  logic [POS_W-1:0]  nxt_pos,
   input  logic              over,
   output logic [POS_W-1:0]  pos_q,
   output tcs_err_e          err_q,
   output logic              busy_q,
   output logic              tuned_q,
   output logic              done_q,
   output logic [GRID_W-1:0] grid_q,
   output logic              dir_dn,
   output logic [POS_W-1:0]  limit
);

   localparam int MAX_STEP = 1 << ((1 << GRID_W) - 2);

   generate
      if (TGT_W - 2 < POS_W) begin : g_bad_tgt
         $error("tcs_ctrl: target needs two spare bits above the position");
      end
   endgenerate

   logic [TGT_W-1:0] tgt_q;
   logic             srch_q;
   logic             range_bad;

   assign dir_dn    = tgt_q[TGT_W-1];
   assign limit     = tgt_q[POS_W-1:0];
   assign range_bad = |tgt_q[TGT_W-1:POS_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q   <= '0;
         grid_q  <= '0;
         srch_q  <= 1'b0;
         busy_q  <= 1'b0;
         pos_q   <= '0;
         err_q   <= ERR_RST;
         tuned_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (!pwr_en) begin
               tuned_q <= 1'b0;
            end
            if (start_req && pwr_en) begin
               busy_q  <= 1'b1;
               err_q   <= ERR_BUSY;
               tuned_q <= 1'b0;
               tgt_q   <= tgt_full;
               grid_q  <= grid_sel;
               srch_q  <= (grid_sel != '0);
            end
         end else if (abort_req || !pwr_en) begin
            busy_q <= 1'b0;
            err_q  <= ERR_FORCE;
            done_q <= 1'b1;
         end else if (!srch_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            if (range_bad) begin
               err_q <= ERR_DAC;
            end else begin
               pos_q   <= tgt_q[POS_W-1:0];
               err_q   <= ERR_OK;
               tuned_q <= 1'b1;
            end
         end else if (stn_found) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            err_q   <= ERR_OK;
            tuned_q <= 1'b1;
         end else if (over) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            err_q  <= ERR_BAND;
         end else begin
            pos_q <= nxt_pos;
         end
      end
   end

   assert_busy_reads_seven_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (err_q == ERR_BUSY));

   assert_not_tuned_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !tuned_q);

   assert_step_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && srch_q) |=> ((POS_W'(pos_q - $past(pos_q)) <= POS_W'(MAX_STEP)) ||
                               (POS_W'($past(pos_q) - pos_q) <= POS_W'(MAX_STEP))));

   assert_abort_forces_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && abort_req) |=> (!busy_q && done_q && err_q == ERR_FORCE));

   assert_power_off_untuned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |=> !tuned_q);

   assert_done_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/tune_cmd_seq.sv
module tune_cmd_seq
   import tcs_pkg::*;
#(
   parameter int POS_W    = 10,
   parameter int BYTE_W   = 8,
   parameter int GRID_W   = 2,
   parameter int BAND_MAX = (1 << POS_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tgt_lo_wr,
   input  logic              tgt_hi_wr,
   input  logic [BYTE_W-1:0] tgt_byte,
   input  logic [GRID_W-1:0] grid_sel,
   input  logic              pwr_en,
   input  logic              abort_req,
   input  logic              stn_found,
   output logic [POS_W-1:0]  tune_pos,
   output logic [2:0]        err_code,
   output logic              busy,
   output logic              tuned,
   output logic              cmd_done
);

   localparam int TGT_W = 2 * BYTE_W;

   logic [TGT_W-1:0]  tgt_full;
   logic              start_req;
   logic [POS_W-1:0]  nxt_pos;
   logic              over;
   logic [POS_W-1:0]  pos_q;
   tcs_err_e          err_q;
   logic              busy_q;
   logic [GRID_W-1:0] grid_q;
   logic              dir_dn;
   logic [POS_W-1:0]  limit;

   tcs_target_reg #(.BYTE_W(BYTE_W), .TGT_W(TGT_W)) u_tgt (
      .clk      (clk),
      .rst_n    (rst_n),
      .lo_wr    (tgt_lo_wr),
      .hi_wr    (tgt_hi_wr),
      .hold     (busy_q),
      .byte_in  (tgt_byte),
      .tgt_full (tgt_full),
      .start_req(start_req)
   );

   tcs_stepper #(.POS_W(POS_W), .GRID_W(GRID_W), .BAND_MAX(BAND_MAX)) u_step (
      .pos    (pos_q),
      .grid   (grid_q),
      .dir_dn (dir_dn),
      .limit  (limit),
      .nxt_pos(nxt_pos),
      .over   (over)
   );

   tcs_ctrl #(.POS_W(POS_W), .TGT_W(TGT_W), .GRID_W(GRID_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_req(start_req),
      .tgt_full (tgt_full),
      .grid_sel (grid_sel),
      .pwr_en   (pwr_en),
      .abort_req(abort_req),
      .stn_found(stn_found),
      .nxt_pos  (nxt_pos),
      .over     (over),
      .pos_q    (pos_q),
      .err_q    (err_q),
      .busy_q   (busy_q),
      .tuned_q  (tuned),
      .done_q   (cmd_done),
      .grid_q   (grid_q),
      .dir_dn   (dir_dn),
      .limit    (limit)
   );

   assign tune_pos = pos_q;
   assign err_code = err_q;
   assign busy     = busy_q;

endmodule

// File: tb/sim_tune_cmd_seq.sv
`timescale 1ns/1ps
module sim_tune_cmd_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tgt_lo_wr = 1'b0;
   logic       tgt_hi_wr = 1'b0;
   logic [7:0] tgt_byte = '0;
   logic [1:0] grid_sel = '0;
   logic       pwr_en = 1'b0;
   logic       abort_req = 1'b0;
   logic       stn_found;
   logic [9:0] tune_pos;
   logic [2:0] err_code;
   logic       busy;
   logic       tuned;
   logic       cmd_done;

   logic       stn_en = 1'b0;
   int         stn_at = 0;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         finished = 1'b0;

   always #10 clk = ~clk;

   assign stn_found = stn_en && (int'(tune_pos) == stn_at);

   tune_cmd_seq u0 (
      .clk(clk), .rst_n(rst_n), .tgt_lo_wr(tgt_lo_wr), .tgt_hi_wr(tgt_hi_wr),
      .tgt_byte(tgt_byte), .grid_sel(grid_sel), .pwr_en(pwr_en),
      .abort_req(abort_req), .stn_found(stn_found), .tune_pos(tune_pos),
      .err_code(err_code), .busy(busy), .tuned(tuned), .cmd_done(cmd_done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr_lo(input int b);
      @(negedge clk);
      tgt_lo_wr = 1'b1;
      tgt_byte  = 8'(b);
      @(posedge clk);
      #1 tgt_lo_wr = 1'b0;
   endtask

   task automatic wait_done(output int nb);
      nb = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (busy) nb++;
         if (cmd_done) return;
      end
      chk("wait_done timeout", 0, 1);
   endtask

   task automatic launch(input int hi, input int grid);
      @(negedge clk);
      grid_sel  = 2'(grid);
      tgt_hi_wr = 1'b1;
      tgt_byte  = 8'(hi);
      @(posedge clk);
      #1 tgt_hi_wr = 1'b0;
   endtask

   task automatic cmd(input int lo, input int hi, input int grid, output int nb);
      wr_lo(lo);
      launch(hi, grid);
      wait_done(nb);
   endtask

   task automatic tune_to(input int p);
      int nb;
      stn_en = 1'b0;
      cmd(p % 256, p / 256, 0, nb);
      chk("R3 direct tune position", int'(tune_pos), p);
   endtask

   task automatic expect_search(input int s0, input int lim, input int st, input bit dn,
                                input bit en, input int f,
                                output int e_pos, output int e_err, output int e_nb);
      int last;
      bit hit;
      if (!dn) begin
         int top = (lim < 1023) ? lim : 1023;
         last = (s0 >= top) ? s0 : s0 + st * ((top - s0) / st);
         hit  = en && f >= s0 && f <= last && ((f - s0) % st) == 0;
      end else begin
         last = (s0 <= lim) ? s0 : s0 - st * ((s0 - lim) / st);
         hit  = en && f <= s0 && f >= last && ((s0 - f) % st) == 0;
      end
      e_pos = hit ? f : last;
      e_err = hit ? 0 : 2;
      e_nb  = (dn ? (s0 - e_pos) : (e_pos - s0)) / st + 1;
   endtask

   task automatic run_search(input string tag, input int s0, input int lim, input int grid,
                             input bit dn, input bit en, input int f);
      int nb, e_pos, e_err, e_nb, st;
      st = 1 << (grid - 1);
      tune_to(s0);
      stn_en = en;
      stn_at = f;
      cmd(lim % 256, (dn ? 128 : 0) + lim / 256, grid, nb);
      expect_search(s0, lim, st, dn, en, f, e_pos, e_err, e_nb);
      chk({tag, " R5/R6 position"}, int'(tune_pos), e_pos);
      chk({tag, " R5/R6 error code"}, int'(err_code), e_err);
      chk({tag, " R5/R6 tuned"}, int'(tuned), e_err == 0 ? 1 : 0);
      chk({tag, " R6 busy cycles"}, nb, e_nb);
      chk({tag, " R10 done with busy fall"}, int'(busy), 0);
      stn_en = 1'b0;
   endtask

   initial begin
      int nb;
      repeat (3) @(negedge clk);
      chk("R1 reset error code", int'(err_code), 1);
      chk("R1 reset position", int'(tune_pos), 0);
      chk("R1 reset busy", int'(busy), 0);
      chk("R1 reset tuned", int'(tuned), 0);
      chk("R1 reset done", int'(cmd_done), 0);
      rst_n = 1'b1;

      // R2: launch with power off is ignored
      wr_lo(5);
      launch(0, 0);
      @(negedge clk);
      chk("R2 power-off launch busy", int'(busy), 0);
      chk("R2 power-off launch error", int'(err_code), 1);

      pwr_en = 1'b1;
      wr_lo(100);
      launch(0, 0);
      @(negedge clk);
      chk("R2 busy after launch", int'(busy), 1);
      chk("R2 error reads busy", int'(err_code), 7);
      @(negedge clk);
      chk("R3 position", int'(tune_pos), 100);
      chk("R3 error code", int'(err_code), 0);
      chk("R3 tuned", int'(tuned), 1);
      chk("R10 done raised", int'(cmd_done), 1);
      @(negedge clk);
      chk("R10 done single cycle", int'(cmd_done), 0);

      // R4: range error
      cmd(7, 8'h04, 0, nb);
      chk("R4 error code", int'(err_code), 3);
      chk("R4 position unchanged", int'(tune_pos), 100);
      chk("R4 tuned", int'(tuned), 0);
      chk("R3 one busy cycle", nb, 1);

      // R11: target join
      cmd(8'h34, 8'h02, 0, nb);
      chk("R11 joined target", int'(tune_pos), 564);

      // Sweep searches
      for (int g = 1; g <= 3; g++) begin
         for (int d = 0; d <= 1; d++) begin
            for (int c = 0; c <= 2; c++) begin
               int st = 1 << (g - 1);
               int off = (c == 0) ? st * 13 : st * 13 + 1;
               int f = d ? 500 - off : 500 + off;
               run_search($sformatf("sweep g%0d d%0d c%0d", g, d, c), 500, d ? 300 : 700,
                          g, d[0], c != 2, f);
            end
         end
      end
      run_search("edge up", 1000, 1023, 3, 1'b0, 1'b0, 0);
      run_search("edge dn", 3, 0, 3, 1'b1, 1'b0, 0);
      run_search("odd dn", 5, 0, 2, 1'b1, 1'b0, 0);
      run_search("past limit", 600, 550, 1, 1'b0, 1'b0, 0);
      run_search("station at start", 200, 900, 3, 1'b0, 1'b1, 200);

      // R9: writes while busy are ignored
      tune_to(0);
      wr_lo(40);
      launch(0, 1);
      nb = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (busy) nb++;
         tgt_lo_wr = (i == 3);
         tgt_hi_wr = (i == 4);
         tgt_byte  = (i == 3) ? 8'd5 : 8'h80;
         if (i == 5) chk("R9 still busy after write", int'(busy), 1);
         if (cmd_done) break;
      end
      tgt_lo_wr = 1'b0;
      tgt_hi_wr = 1'b0;
      chk("R9 limit kept", int'(tune_pos), 40);
      chk("R9 error code", int'(err_code), 2);
      chk("R9 busy cycles", nb, 41);
      launch(0, 0);
      wait_done(nb);
      chk("R9 low byte kept", int'(tune_pos), 40);

      // R7: abort during search, and abort while idle
      tune_to(0);
      wr_lo(255);
      launch(3, 1);
      repeat (5) @(negedge clk);
      abort_req = 1'b1;
      @(posedge clk);
      #1 abort_req = 1'b0;
      @(negedge clk);
      chk("R7 busy after abort", int'(busy), 0);
      chk("R7 error code", int'(err_code), 6);
      chk("R7 tuned", int'(tuned), 0);
      chk("R10 done on abort", int'(cmd_done), 1);
      tune_to(77);
      @(negedge clk);
      abort_req = 1'b1;
      @(posedge clk);
      #1 abort_req = 1'b0;
      @(negedge clk);
      chk("R7 idle abort error", int'(err_code), 0);
      chk("R7 idle abort tuned", int'(tuned), 1);
      chk("R7 idle abort done", int'(cmd_done), 0);

      // R8: power drop
      @(negedge clk);
      pwr_en = 1'b0;
      @(negedge clk);
      chk("R8 tuned cleared", int'(tuned), 0);
      pwr_en = 1'b1;
      tune_to(0);
      wr_lo(255);
      launch(3, 1);
      repeat (4) @(negedge clk);
      pwr_en = 1'b0;
      @(negedge clk);
      chk("R8 busy after power loss", int'(busy), 0);
      chk("R8 error code", int'(err_code), 6);
      chk("R10 done on power loss", int'(cmd_done), 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1-run incomplete actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule